// File: doc/BRIEF.md
# Two-Wire Bus Register Target

This block attaches an on-chip bank of 128 byte-wide registers to a two-wire serial bus as a target. It oversamples the clock and data lines with the system clock, answers its own 7-bit bus address (0x28), and takes the first byte after a write header as a register pointer. Any further bytes in the same write go into consecutive registers. A read header returns consecutive registers, most significant bit first, for as long as the controller acknowledges. The register bank sits outside the block behind a plain port. That port has an address, write data, a one-cycle write strobe and read data that follows the address combinationally.

The block keeps two pointers. The base pointer holds the register address from the most recent write phase and is 0x00 after reset. The current pointer walks through the bank during a transfer and wraps from 0x7F to 0x00. Every read header reloads the current pointer from the base pointer, so the same block of registers can be read again and again without sending the pointer each time. The protocol is one state machine. ST_IDLE goes to ST_DEV on START. ST_DEV goes to ST_DEV_ACK on an address match, or to ST_SKIP on a mismatch. ST_DEV_ACK goes to ST_PTR for a write header or to ST_RDAT for a read header. ST_PTR goes to ST_PTR_ACK, then to ST_WDAT. ST_WDAT and ST_WDAT_ACK alternate while write data arrives. ST_RDAT goes to ST_RDAT_ACK, which returns to ST_RDAT on a controller ACK or goes to ST_SKIP on a NACK. START in any state goes to ST_DEV, and STOP in any state goes to ST_IDLE.

Top module: `twi_reg_target`

## Requirements
- R1: After reset the block releases SDA (sda_pull=0), holds reg_we low and presents reg_addr=0x00.
- R2: An address byte whose upper 7 bits equal 0x28 is acknowledged. Any other address is not acknowledged, and no later byte is acknowledged or written until the next START or STOP.
- R3: In a write, the byte after the header sets the pointer and each following byte is written to the next register in turn. Each such byte is acknowledged and produces exactly one single-cycle reg_we pulse.
- R4: Bit 7 of the pointer byte is ignored; pointer byte 0x85 selects register 0x05.
- R5: The pointer advances by one after every byte moved in either direction and wraps from 0x7F to 0x00.
- R6: In a read, the block drives each register byte MSB first and continues while the controller answers ACK (SDA low). After a NACK (SDA high) it releases SDA.
- R7: Every read transfer starts at the register address of the most recent write phase (0x00 if none since reset), regardless of where an earlier read stopped.
- R8: A START seen in the middle of a byte or a transfer discards the partial byte and expects a new address byte.
- R9: A STOP at any point ends the transfer, releases SDA and writes no partial byte.
- R10: The block changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr | output | 7 | Register bank address (current pointer) |
| reg_wdata | output | 8 | Register bank write data |
| reg_we | output | 1 | Register bank write strobe, one cycle per byte |
| reg_rdata | input | 8 | Register bank read data for reg_addr |

## Verification
The hardest states to reach from the ports are a START or STOP that lands partway through a byte. A correct controller never produces them, so the bench drives the bus bit by bit and cuts bytes off after a chosen number of bits. It then issues the repeated START or STOP and checks that the registers and the following transfer are unaffected. The address decoder is swept over every 7-bit address other than 0x28, with the direction bit varied, to confirm that nothing is acknowledged or written. A full 128-byte write followed by a 128-byte read covers pointer wrap and every register.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_ACK,
        ST_SKIP
    } twi_state_t;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] d_in,
    output logic [LINES-1:0] d_out
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], d_in[g]};
            end
        end

        assign d_out[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    // data edges only count as conditions while the clock stays high
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twi_reg_target.sv
module twi_reg_target
    import twi_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h28,
    parameter int         AW          = 7,
    parameter int         DW          = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_pull,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_we,
    input  logic [DW-1:0] reg_rdata
);

    localparam int CW = $clog2(DW + 1);

    logic [1:0] sync_q;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_ev, stop_ev;

    twi_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({scl_in, sda_in}),
        .d_out (sync_q)
    );
    assign scl_s = sync_q[1];
    assign sda_s = sync_q[0];

    twi_bus_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    twi_state_t    state, state_nx;
    logic [CW-1:0] cnt;
    logic [DW-1:0] shreg;
    logic [AW-1:0] base_ptr, cur_ptr;
    logic          rw_bit;
    logic          ack_seen;
    logic          byte_done;
    logic          addr_match;

    assign byte_done  = (cnt == CW'(DW));
    assign addr_match = (shreg[DW-1:1] == DEV_ADDR);
    assign reg_addr   = cur_ptr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (stop_ev) begin
            state_nx = ST_IDLE;
        end else if (start_ev) begin
            state_nx = ST_DEV;
        end else if (scl_fall) begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_DEV:      if (byte_done) state_nx = addr_match ? ST_DEV_ACK : ST_SKIP;
                ST_DEV_ACK:  if (cnt != '0) state_nx = rw_bit ? ST_RDAT : ST_PTR;
                ST_PTR:      if (byte_done) state_nx = ST_PTR_ACK;
                ST_PTR_ACK:  if (cnt != '0) state_nx = ST_WDAT;
                ST_WDAT:     if (byte_done) state_nx = ST_WDAT_ACK;
                ST_WDAT_ACK: if (cnt != '0) state_nx = ST_WDAT;
                ST_RDAT:     if (byte_done) state_nx = ST_RDAT_ACK;
                ST_RDAT_ACK: if (cnt != '0) state_nx = ack_seen ? ST_RDAT : ST_SKIP;
                ST_SKIP:     state_nx = ST_SKIP;
            endcase
        end
    end

    // datapath: bit counter, shifter, pointers, write strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            shreg     <= '0;
            base_ptr  <= '0;
            cur_ptr   <= '0;
            rw_bit    <= 1'b0;
            ack_seen  <= 1'b0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            if (reg_we) cur_ptr <= cur_ptr + 1'b1;

            if (start_ev || stop_ev) begin
                cnt <= '0;
            end else if (scl_rise) begin
                case (state)
                    ST_DEV, ST_PTR, ST_WDAT: begin
                        shreg <= {shreg[DW-2:0], sda_s};
                        cnt   <= cnt + 1'b1;
                    end
                    ST_RDAT_ACK: begin
                        ack_seen <= ~sda_s;
                        cnt      <= cnt + 1'b1;
                    end
                    ST_DEV_ACK, ST_PTR_ACK, ST_WDAT_ACK, ST_RDAT: begin
                        cnt <= cnt + 1'b1;
                    end
                    default: ;
                endcase
            end else if (scl_fall) begin
                case (state)
                    ST_DEV: if (byte_done) begin
                        cnt    <= '0;
                        rw_bit <= shreg[0];
                        if (addr_match && shreg[0]) cur_ptr <= base_ptr;
                    end
                    ST_PTR: if (byte_done) begin
                        cnt      <= '0;
                        base_ptr <= shreg[AW-1:0];
                        cur_ptr  <= shreg[AW-1:0];
                    end
                    ST_WDAT: if (byte_done) begin
                        cnt       <= '0;
                        reg_we    <= 1'b1;
                        reg_wdata <= shreg;
                    end
                    ST_DEV_ACK: if (cnt != '0) begin
                        cnt <= '0;
                        if (rw_bit) begin
                            shreg   <= reg_rdata;
                            cur_ptr <= cur_ptr + 1'b1;
                        end
                    end
                    ST_PTR_ACK, ST_WDAT_ACK: if (cnt != '0) cnt <= '0;
                    ST_RDAT: begin
                        if (byte_done)        cnt   <= '0;
                        else if (cnt != '0)   shreg <= {shreg[DW-2:0], 1'b0};
                    end
                    ST_RDAT_ACK: if (cnt != '0) begin
                        cnt <= '0;
                        if (ack_seen) begin
                            shreg   <= reg_rdata;
                            cur_ptr <= cur_ptr + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_PTR_ACK, ST_WDAT_ACK: sda_pull = 1'b1;
            ST_RDAT:                             sda_pull = ~shreg[DW-1];
            default:                             sda_pull = 1'b0;
        endcase
    end

    // ---------------- assertions ----------------
    p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_addr == AW'($past(reg_addr) + 1'b1)));

    p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_pull) || $fell(sda_pull)) |-> !scl_s);

    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE && !sda_pull));

    p_start_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_DEV && cnt == '0));

    p_skip_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!sda_pull && !reg_we));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DW));

endmodule

// File: tb/sim_twi_reg_target.sv
module sim_twi_reg_target;

    localparam int         Q   = 6;
    localparam logic [6:0] TGT = 7'h28;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_ctl = 1'b1;
    logic       sda_ctl = 1'b1;
    logic       sda_pull;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic [7:0] reg_rdata;
    wire        sda_line = sda_ctl & ~sda_pull;

    logic [7:0] mem     [128];
    logic [7:0] exp_mem [128];
    int we_count = 0;
    int total = 0;
    int bad = 0;

    assign reg_rdata = mem[reg_addr];

    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_count++;
        end
    end

    twi_reg_target u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_ctl),
        .sda_in    (sda_line),
        .sda_pull  (sda_pull),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata)
    );

    function automatic logic [7:0] dval(input int d, input int salt);
        return 8'(d * 13 + 7 + salt * 29) ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qd();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_ctl = 1'b1; scl_ctl = 1'b1; qd();
        sda_ctl = 1'b0; qd();
        scl_ctl = 1'b0; qd();
    endtask

    task automatic bus_rstart();
        sda_ctl = 1'b1; qd();
        scl_ctl = 1'b1; qd();
        sda_ctl = 1'b0; qd();
        scl_ctl = 1'b0; qd();
    endtask

    task automatic bus_stop();
        sda_ctl = 1'b0; qd();
        scl_ctl = 1'b1; qd();
        sda_ctl = 1'b1; qd();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_ctl = b[i]; qd();
            scl_ctl = 1'b1; qd(); qd();
            scl_ctl = 1'b0; qd();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_ctl = 1'b1; qd();
        scl_ctl = 1'b1; qd();
        acked = ~sda_line;
        qd();
        scl_ctl = 1'b0; qd();
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit more);
        b = '0;
        sda_ctl = 1'b1;
        for (int i = 0; i < 8; i++) begin
            qd();
            scl_ctl = 1'b1; qd();
            b = {b[6:0], sda_line};
            qd();
            scl_ctl = 1'b0;
        end
        qd();
        sda_ctl = more ? 1'b0 : 1'b1; qd();
        scl_ctl = 1'b1; qd(); qd();
        scl_ctl = 1'b0; qd();
        sda_ctl = 1'b1;
    endtask

    task automatic wr_seq(input logic [7:0] ptrb, input int n, input int salt, input string tag);
        bit a;
        bus_start();
        send_byte({TGT, 1'b0}, a); chk(a, {tag, " header ack (R2)"}, a, 1);
        send_byte(ptrb, a);        chk(a, {tag, " pointer ack"}, a, 1);
        for (int k = 0; k < n; k++) begin
            int d = (int'(ptrb[6:0]) + k) % 128;
            logic [7:0] v = dval(d, salt);
            send_byte(v, a);
            chk(a, {tag, " data ack"}, a, 1);
            exp_mem[d] = v;
        end
        bus_stop();
    endtask

    task automatic rd_seq(input int n, input bit with_ptr, input logic [6:0] ptr,
                          input logic [6:0] first, input string tag);
        bit a;
        logic [7:0] b;
        bus_start();
        if (with_ptr) begin
            send_byte({TGT, 1'b0}, a); chk(a, {tag, " write-phase ack"}, a, 1);
            send_byte({1'b0, ptr}, a); chk(a, {tag, " pointer ack"}, a, 1);
            bus_rstart();
        end
        send_byte({TGT, 1'b1}, a); chk(a, {tag, " read header ack (R2)"}, a, 1);
        for (int k = 0; k < n; k++) begin
            int d = (int'(first) + k) % 128;
            recv_byte(b, k < n - 1);
            chk(b == exp_mem[d], tag, b, exp_mem[d]);
        end
        qd();
        chk(!sda_pull, {tag, " SDA released after NACK (R6)"}, sda_pull, 0);
        bus_stop();
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit a, a2;
        int c0;
        for (int i = 0; i < 128; i++) begin
            mem[i]     = 8'(i * 37 + 5);
            exp_mem[i] = 8'(i * 37 + 5);
        end
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(sda_pull == 1'b0, "R1 sda_pull", sda_pull, 0);
        chk(reg_we == 1'b0, "R1 reg_we", reg_we, 0);
        chk(reg_addr == 7'h00, "R1 reg_addr", reg_addr, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R7: no pointer written since reset -> read starts at 0x00
        rd_seq(4, 1'b0, 7'h00, 7'h00, "R7 default start");

        // R3: write five bytes from 0x10
        wr_seq(8'h10, 5, 1, "R3 write");
        for (int d = 16; d < 21; d++)
            chk(mem[d] == exp_mem[d], "R3 bank content", mem[d], exp_mem[d]);

        // R6: read with pointer + repeated start
        rd_seq(5, 1'b1, 7'h10, 7'h10, "R6 read");
        // R7: re-read twice without pointer, always from 0x10
        rd_seq(5, 1'b0, 7'h00, 7'h10, "R7 reread");
        rd_seq(3, 1'b0, 7'h00, 7'h10, "R7 reread again");

        // R4: pointer MSB ignored
        wr_seq(8'h85, 2, 2, "R4 write");
        chk(mem[5] == exp_mem[5], "R4 lands at 0x05", mem[5], exp_mem[5]);
        rd_seq(2, 1'b0, 7'h00, 7'h05, "R4 readback");

        // R5: wrap on writes and reads
        wr_seq(8'h7E, 3, 3, "R5 write");
        chk(mem[126] == exp_mem[126], "R5 0x7E", mem[126], exp_mem[126]);
        chk(mem[127] == exp_mem[127], "R5 0x7F", mem[127], exp_mem[127]);
        chk(mem[0] == exp_mem[0], "R5 wrap to 0x00", mem[0], exp_mem[0]);
        rd_seq(4, 1'b0, 7'h00, 7'h7E, "R5 read wrap");

        // R8: repeated START after 3 bits of a data byte
        bus_start();
        send_byte({TGT, 1'b0}, a); chk(a, "R8 header", a, 1);
        send_bits(8'hC3, 3);
        bus_rstart();
        send_byte({TGT, 1'b0}, a); chk(a, "R8 header after restart", a, 1);
        send_byte(8'h20, a);       chk(a, "R8 pointer", a, 1);
        send_byte(8'h77, a);       chk(a, "R8 data", a, 1);
        bus_stop();
        exp_mem[32] = 8'h77;
        chk(mem[32] == 8'h77, "R8 write after restart", mem[32], 8'h77);
        // R8: repeated START in the middle of the address byte
        bus_start();
        send_bits(8'h51, 5);
        bus_rstart();
        send_byte({TGT, 1'b1}, a); chk(a, "R8 read header after cut address", a, 1);
        begin
            logic [7:0] b;
            recv_byte(b, 1'b0);
            chk(b == exp_mem[32], "R8 read after cut address", b, exp_mem[32]);
        end
        bus_stop();

        // R9: STOP in the middle of a data byte
        c0 = we_count;
        bus_start();
        send_byte({TGT, 1'b0}, a); chk(a, "R9 header", a, 1);
        send_byte(8'h30, a);       chk(a, "R9 pointer", a, 1);
        send_bits(8'h0F, 4);
        bus_stop();
        qd();
        chk(!sda_pull, "R9 SDA released", sda_pull, 0);
        chk(we_count == c0, "R9 no partial write", we_count, c0);
        chk(mem[48] == exp_mem[48], "R9 register untouched", mem[48], exp_mem[48]);
        rd_seq(1, 1'b0, 7'h00, 7'h30, "R9 next transfer");

        // R3/R5/R6: full bank write then full read
        wr_seq(8'h00, 128, 4, "R3 full write");
        rd_seq(128, 1'b1, 7'h00, 7'h00, "R6 full read");

        // R2: every other address is ignored
        c0 = we_count;
        for (int ad = 0; ad < 128; ad++) begin
            if (ad != int'(TGT)) begin
                bus_start();
                send_byte({7'(ad), 1'(ad)}, a);
                send_byte(8'h00, a2);
                chk(!a && !a2, "R2 foreign address ignored", {a, a2}, 0);
                bus_stop();
            end
        end
        chk(we_count == c0, "R2 no writes for foreign address", we_count, c0);
        rd_seq(2, 1'b1, 7'h40, 7'h40, "R2 recovery read");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule